// File: doc/BRIEF.md
# Registered One-Hot Response Merger

This block folds a set of response channels into one. Every channel brings a valid bit and a data word. The surrounding system is designed so that at most one channel responds in any cycle. The block registers the merged valid bit and the merged data word on the rising clock edge.

The data path treats the valid vector as a one-hot select, not as a binary index. Each word is gated by its own valid bit, and the gated words are combined with a bitwise OR. This keeps the logic a balanced AND-OR tree with no priority between channels.

A build parameter can drop the gating. That suits systems in which every idle channel already drives zeros, and then the word output is the plain OR of all words. In both builds the word output is forced to zero in any cycle with no valid input. A registered flag marks each cycle in which more than one valid bit was set.

Top module: `resp_merge`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the next clock edge drives `mergedValid`, `mergedData` and `collideFlag` to 0, whatever the inputs are.
- R2: One clock edge after the inputs are sampled, `mergedValid` is 1 when at least one bit of `chanValid` was set and 0 otherwise.
- R3: In the gated build (`SKIP_MASK`=0), when exactly one valid bit k is set, `mergedData` in the next cycle equals word k, even if the idle channels present nonzero words. Word i occupies bits [i*WIDTH +: WIDTH] of `chanData`.
- R4: When no valid bit is set, `mergedValid` and `mergedData` are both zero in the next cycle, in both builds and for any idle data.
- R5: `collideFlag` is 1 in the cycle after two or more valid bits were set, and 0 after idle or one-hot inputs.
- R6: In the gated build, a multi-hot input gives a `mergedData` equal to the bitwise OR of the words of the valid channels only.
- R7: In the ungated build (`SKIP_MASK`=1), whenever at least one valid bit is set, `mergedData` is the bitwise OR of all channel words, valid or not.
- R8: Selection has no priority: the lowest channel and the highest channel are each passed through unchanged when they are the only valid channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| chanValid | input | CHANNELS | Per-channel valid bits, expected one-hot or zero |
| chanData | input | CHANNELS*WIDTH | Channel words, channel i at bits [i*WIDTH +: WIDTH] |
| mergedValid | output | 1 | Registered OR of all valid bits |
| mergedData | output | WIDTH | Registered merged word |
| collideFlag | output | 1 | Registered multi-hot indication |

## Verification
The bench builds two instances side by side with five channels of twelve bits. One uses the gated build and one the ungated build, and both see the same stimulus. Five is not a power of two, so the edge channel 4 and an uneven OR tree get exercised. Because both builds share the stimulus, the same garbage on idle channels must be hidden by one build and merged by the other, which separates R3 from R7. Idle, one-hot, two-hot and all-hot patterns, plus a reset applied while traffic is active, cover the flag and the zero idle output.

// File: rtl/resp_merge_pkg.sv
package resp_merge_pkg;
  // Strobes handed from the control half to the datapath half.
  typedef struct packed {
    logic anyHit;    // at least one valid bit set this cycle
    logic multiHit;  // two or more valid bits set this cycle
  } merge_strobe_t;
endpackage

// File: rtl/resp_merge_ctrl.sv
module resp_merge_ctrl
  import resp_merge_pkg::*;
#(
  parameter int CHANNELS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CHANNELS-1:0] chanValid,
  output merge_strobe_t       strb,
  output logic                validQ,
  output logic                collideQ
);
  // Running scan: seenOne latches on the first set bit, seenTwo on the next.
  always_comb begin
    logic seenOne;
    logic seenTwo;
    seenOne = 1'b0;
    seenTwo = 1'b0;
    for (int i = 0; i < CHANNELS; i++) begin
      if (chanValid[i]) begin
        if (seenOne) seenTwo = 1'b1;
        seenOne = 1'b1;
      end
    end
    strb.anyHit   = seenOne;
    strb.multiHit = seenTwo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ   <= 1'b0;
      collideQ <= 1'b0;
    end else begin
      validQ   <= strb.anyHit;
      collideQ <= strb.multiHit;
    end
  end

  // R2: the registered valid tracks the sampled valid vector
  p_valid_set_r2: assert property (@(posedge clk) disable iff (rst)
    (chanValid != '0) |=> validQ);
  p_valid_clr_r2: assert property (@(posedge clk) disable iff (rst)
    (chanValid == '0) |=> !validQ);
  // R5: flag set exactly after multi-hot inputs
  p_collide_set_r5: assert property (@(posedge clk) disable iff (rst)
    ($countones(chanValid) > 1) |=> collideQ);
  p_collide_clr_r5: assert property (@(posedge clk) disable iff (rst)
    ($countones(chanValid) <= 1) |=> !collideQ);
endmodule

// File: rtl/resp_merge_datapath.sv
module resp_merge_datapath
  import resp_merge_pkg::*;
#(
  parameter int CHANNELS  = 8,
  parameter int WIDTH     = 32,
  parameter bit SKIP_MASK = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CHANNELS-1:0]       chanValid,
  input  logic [CHANNELS*WIDTH-1:0] chanData,
  input  merge_strobe_t             strb,
  output logic [WIDTH-1:0]          dataQ
);
  localparam int TOTAL = CHANNELS * WIDTH;

  logic [TOTAL-1:0] termVec;
  logic [WIDTH-1:0] orAll;

  // Per-channel term: gated by its valid bit, or passed straight through.
  for (genvar g = 0; g < CHANNELS; g++) begin : g_term
    if (SKIP_MASK) begin : g_raw
      assign termVec[g*WIDTH +: WIDTH] = chanData[g*WIDTH +: WIDTH];
    end else begin : g_gate
      assign termVec[g*WIDTH +: WIDTH] =
        chanData[g*WIDTH +: WIDTH] & {WIDTH{chanValid[g]}};
    end
  end

  always_comb begin
    orAll = '0;
    for (int i = 0; i < CHANNELS; i++) orAll |= termVec[i*WIDTH +: WIDTH];
  end

  always_ff @(posedge clk) begin
    if (rst)              dataQ <= '0;
    else if (!strb.anyHit) dataQ <= '0;
    else                  dataQ <= orAll;
  end

  // R4: an idle cycle always leaves a zero word behind
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !strb.anyHit |=> (dataQ == '0));
  // R5: the control never reports multi-hot without a hit
  p_strobe_consistent_r5: assert property (@(posedge clk) disable iff (rst)
    strb.multiHit |-> strb.anyHit);
endmodule

// File: rtl/resp_merge.sv
module resp_merge
  import resp_merge_pkg::*;
#(
  parameter int CHANNELS  = 8,
  parameter int WIDTH     = 32,
  parameter bit SKIP_MASK = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CHANNELS-1:0]       chanValid,
  input  logic [CHANNELS*WIDTH-1:0] chanData,
  output logic                      mergedValid,
  output logic [WIDTH-1:0]          mergedData,
  output logic                      collideFlag
);
  merge_strobe_t strb;

  resp_merge_ctrl #(.CHANNELS(CHANNELS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .chanValid(chanValid),
    .strb     (strb),
    .validQ   (mergedValid),
    .collideQ (collideFlag)
  );

  resp_merge_datapath #(
    .CHANNELS (CHANNELS),
    .WIDTH    (WIDTH),
    .SKIP_MASK(SKIP_MASK)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .chanValid(chanValid),
    .chanData (chanData),
    .strb     (strb),
    .dataQ    (mergedData)
  );

  // R4: invalid output carries a zero word
  p_invalid_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !mergedValid |-> (mergedData == '0));
  // R5: a collision implies a valid output
  p_collide_valid_r5: assert property (@(posedge clk) disable iff (rst)
    collideFlag |-> mergedValid);
endmodule

// File: tb/resp_merge_test.sv
module resp_merge_test;
  localparam int CH = 5;
  localparam int W  = 12;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [CH-1:0]   vIn = '0;
  logic [CH*W-1:0] dIn = '0;

  logic          vGate, cGate, vRaw, cRaw;
  logic [W-1:0]  dGate, dRaw;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  resp_merge #(.CHANNELS(CH), .WIDTH(W), .SKIP_MASK(1'b0)) uut (
    .clk(clk), .rst(rst), .chanValid(vIn), .chanData(dIn),
    .mergedValid(vGate), .mergedData(dGate), .collideFlag(cGate));

  resp_merge #(.CHANNELS(CH), .WIDTH(W), .SKIP_MASK(1'b1)) uutRaw (
    .clk(clk), .rst(rst), .chanValid(vIn), .chanData(dIn),
    .mergedValid(vRaw), .mergedData(dRaw), .collideFlag(cRaw));

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Apply one input pattern, clock it, and compare one edge later.
  task automatic step(logic [CH-1:0] v, logic [CH*W-1:0] d, string note);
    int hits;
    logic [W-1:0] expGate;
    logic [W-1:0] expRaw;
    vIn = v;
    dIn = d;
    hits = 0;
    expGate = '0;
    expRaw  = '0;
    for (int i = 0; i < CH; i++) begin
      if (v[i]) begin
        hits++;
        expGate |= d[i*W +: W];
      end
      expRaw |= d[i*W +: W];
    end
    if (hits == 0) expRaw = '0;
    @(posedge clk);
    #1;
    check({"R2 valid gated ", note}, W'(vGate), W'(hits > 0));
    check({"R2 valid raw ", note},   W'(vRaw),  W'(hits > 0));
    check({"R5 flag gated ", note},  W'(cGate), W'(hits > 1));
    check({"R5 flag raw ", note},    W'(cRaw),  W'(hits > 1));
    if (hits == 0) begin
      check({"R4 idle gated ", note}, dGate, '0);
      check({"R4 idle raw ", note},   dRaw,  '0);
    end else if (hits == 1) begin
      check({"R3 select ", note}, dGate, expGate);
      check({"R7 raw or ", note}, dRaw,  expRaw);
    end else begin
      check({"R6 gated or ", note}, dGate, expGate);
      check({"R7 raw or ", note},   dRaw,  expRaw);
    end
  endtask

  function automatic logic [CH*W-1:0] rndData();
    logic [CH*W-1:0] r;
    for (int i = 0; i < CH; i++) r[i*W +: W] = W'($urandom);
    return r;
  endfunction

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset with active garbage inputs
    vIn = '1;
    dIn = rndData();
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", W'(vGate), '0);
    check("R1 reset data",  dGate, '0);
    check("R1 reset flag",  W'(cGate), '0);
    check("R1 reset data raw", dRaw, '0);
    rst = 1'b0;

    step('0, rndData(), "idle garbage");
    step(5'b00001, rndData(), "R8 lowest channel");
    step(5'b10000, rndData(), "R8 highest channel");
    step(5'b00100, {CH*W{1'b1}}, "ones on idle");
    step(5'b00110, rndData(), "two hot");
    step('1, rndData(), "all hot");
    step('0, '0, "idle zero");

    for (int n = 0; n < 400; n++) begin
      int kind;
      logic [CH-1:0] v;
      kind = int'($urandom_range(0, 3));
      v = '0;
      if (kind == 1 || kind == 2) v[$urandom_range(0, CH-1)] = 1'b1;
      else if (kind == 3) v = CH'($urandom);
      step(v, rndData(), "random");
    end

    // R1: reset in the middle of traffic
    vIn = 5'b01000;
    dIn = rndData();
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 mid reset valid", W'(vGate), '0);
    check("R1 mid reset data",  dGate, '0);
    check("R1 mid reset flag raw", W'(cRaw), '0);
    rst = 1'b0;
    step(5'b01000, rndData(), "after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule